// File: doc/BRIEF.md
# Device Address Translation Walker

This block converts an address issued by a DMA-capable device into a physical address. A request names the device, the DMA address and whether the access is a read or a write. The walker reads a 32-byte per-device entry from a table in memory. If the entry enables translation, the walker follows a chain of 8-byte page-table entries, one per level, down to a leaf that supplies the physical page. At every non-leaf step it confirms that the entry is present and that it grants the requested access.

The result is one of three outcomes. The address can pass through unchanged with an unlimited length. It can be translated, in which case the length reported is the number of bytes left in the 4 KiB page. Otherwise the request faults. A fault also raises a one-cycle event carrying the device, domain, address and flags, for an event-log writer to consume. All memory traffic uses a single read port with a request/grant handshake followed by a read-valid return. Only one translation is in flight at a time.

Top module: `iommu_walker`

## Requirements
- R1: When `enable_i` is low at acceptance, the walker issues no memory read. One cycle later it responds without fault, with `rsp_addr_o` equal to the request address and `rsp_len_o` all ones.
- R2: The first quadword of the device entry is read from `dtab_base_i`×4096 + device×32. The second quadword is read from that address + 8, and its bits 15:0 are the domain.
- R3: If bit 0 (valid) or bit 1 (translation enabled) of the first device quadword is 0, the walker responds without fault with the request address and an all-ones length, after exactly one memory read.
- R4: An entry holds its level in bits 11:9 and its next-table pointer in bits 51:12. The child entry is read from pointer×4096 + 8×index. At level L the 9-bit index is the DMA address bits starting at bit 12+9×(L−1), with bits above 63 read as 0.
- R5: A non-leaf entry whose bit 0 (present) is 0 causes a fault. The event reports present = 0.
- R6: A non-leaf entry must have bit 61 set for a read or bit 62 set for a write. Otherwise the request faults with present = 1 and the event write flag equal to the request direction.
- R7: An entry with level 0 ends the walk, and its present and permission bits are not checked. The result is pointer×4096 + DMA address bits 11:0, and the length is 4096 minus those 11:0 bits.
- R8: A device entry with level 7 faults. A fetched entry whose level is 7, or is not below the level of its parent, also faults, with the event present flag taken from that entry's bit 0.
- R9: A faulting response pulses `evt_valid_o` in the same cycle, with device, domain, DMA address, present and write flags. A non-faulting response never pulses it.
- R10: `req_ready_o` falls in the cycle after a request is accepted. It stays low until the single-cycle response and is high again in the cycle after it.
- R11: A read request and its address are held until granted. A translation makes at most 8 memory reads (two device quadwords plus six levels).
- R12: After reset, `req_ready_o` is high, and `rsp_valid_o`, `mem_req_o` and `evt_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global translation enable |
| dtab_base_i | input | PA_W-12 | Device table base, 4 KiB page number |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_dev_i | input | DEV_W | Requesting device ID |
| req_addr_i | input | VA_W | DMA address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| rsp_valid_o | output | 1 | Result valid, one cycle |
| rsp_fault_o | output | 1 | Request faulted |
| rsp_addr_o | output | VA_W | Translated or passed-through address |
| rsp_len_o | output | VA_W | Bytes left in page, all ones if untranslated |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | PA_W | Memory read address (8-byte aligned) |
| mem_gnt_i | input | 1 | Read request granted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data quadword |
| evt_valid_o | output | 1 | Fault event pulse |
| evt_dev_o | output | DEV_W | Faulting device |
| evt_domain_o | output | 16 | Domain of the faulting device |
| evt_addr_o | output | VA_W | Faulting DMA address |
| evt_present_o | output | 1 | Present flag of the offending entry |
| evt_write_o | output | 1 | Direction of the faulting access |

## Verification
The bench builds page tables in a sparse memory model and varies the grant delay. It then compares every response, event and read count against a walk computed from the requirements. The corner cases it targets are these:
- A six-level walk with high address bits. An off-by-one in the index shift would land on unpopulated entries and translate to a wrong page.
- A leaf entry that is not present and grants nothing. A walker that checks leaves would fault on it.
- Read-only and write-only entries in both directions. Swapped permission bits would fault the legal direction.
- Non-decreasing and level-7 entries. A walker without the sanity check would loop, or read past the six-level bound.
- A large device number and entries that are valid but not translated. A wrong entry stride or a wrong flag test would return the wrong passthrough decision.

// File: rtl/iommu_walk_pkg.sv
package iommu_walk_pkg;
  localparam int unsigned PG_SHIFT    = 12;
  localparam int unsigned IDX_W       = 9;
  localparam int unsigned LVL_LSB     = 9;
  localparam int unsigned LVL_W       = 3;
  localparam int unsigned ENT_W       = 64;
  localparam int unsigned DOM_W       = 16;
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_XLAT    = 1;
  localparam int unsigned BIT_RD      = 61;
  localparam int unsigned BIT_WR      = 62;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DTE0, ST_DTE1, ST_CHECK, ST_PTE, ST_RESP
  } walk_st_e;

  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_WAIT} rd_st_e;
endpackage

// File: rtl/iw_entry_chk.sv
module iw_entry_chk
  import iommu_walk_pkg::*;
#(
  parameter int unsigned MAX_LVL = 6
) (
  input  logic             cur_present_i,
  input  logic             cur_rd_i,
  input  logic             cur_wr_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             req_write_i,
  input  logic [LVL_W-1:0] new_lvl_i,
  output logic             cur_fault_o,
  output logic             new_bad_o
);
  logic perm_ok;

  // permission implication: requested access must be granted
  assign perm_ok     = req_write_i ? cur_wr_i : cur_rd_i;
  assign cur_fault_o = (int'(cur_lvl_i) > MAX_LVL) || !cur_present_i || !perm_ok;
  assign new_bad_o   = (int'(new_lvl_i) > MAX_LVL) || (new_lvl_i >= cur_lvl_i);
endmodule

// File: rtl/iw_addr_gen.sv
module iw_addr_gen
  import iommu_walk_pkg::*;
#(
  parameter int unsigned DEV_W = 16,
  parameter int unsigned VA_W  = 64,
  parameter int unsigned PA_W  = 52
) (
  input  logic [PA_W-PG_SHIFT-1:0] tbl_base_i,
  input  logic [DEV_W-1:0]         dev_i,
  input  logic                     sel_hi_i,
  input  logic [PA_W-PG_SHIFT-1:0] root_i,
  input  logic [LVL_W-1:0]         lvl_i,
  input  logic [VA_W-1:0]          va_i,
  output logic [PA_W-1:0]          dte_addr_o,
  output logic [PA_W-1:0]          next_addr_o,
  output logic [VA_W-1:0]          xlat_addr_o,
  output logic [VA_W-1:0]          xlat_len_o
);
  localparam int unsigned DTE_SH = 5;            // 32-byte device entries
  localparam int unsigned OFF_W  = PG_SHIFT + 1;

  logic [7:0]       shamt;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] remain;

  assign dte_addr_o = {tbl_base_i, {PG_SHIFT{1'b0}}}
                    + (PA_W'(dev_i) << DTE_SH)
                    + (sel_hi_i ? PA_W'(8) : PA_W'(0));

  always_comb begin
    if (lvl_i == '0) shamt = 8'd0;
    else             shamt = 8'(PG_SHIFT + IDX_W * (int'(lvl_i) - 1));
  end

  assign idx         = IDX_W'(va_i >> shamt);
  assign next_addr_o = {root_i, {PG_SHIFT{1'b0}}} + PA_W'({idx, 3'b000});
  assign xlat_addr_o = VA_W'({root_i, va_i[PG_SHIFT-1:0]});
  assign remain      = OFF_W'(1 << PG_SHIFT) - OFF_W'(va_i[PG_SHIFT-1:0]);
  assign xlat_len_o  = VA_W'(remain);
endmodule

// File: rtl/iw_rd_port.sv
module iw_rd_port
  import iommu_walk_pkg::*;
#(
  parameter int unsigned PA_W = 52
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [PA_W-1:0] addr_i,
  output logic            mem_req_o,
  output logic [PA_W-1:0] mem_addr_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  output logic            done_o
);
  rd_st_e          st_q;
  logic [PA_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RD_IDLE;
      addr_q <= '0;
    end else if (start_i) begin
      addr_q <= addr_i;
      st_q   <= RD_REQ;
    end else begin
      unique case (st_q)
        RD_REQ:  if (mem_gnt_i) st_q <= RD_WAIT;
        RD_WAIT: if (mem_rvalid_i) st_q <= RD_IDLE;
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == RD_REQ);
  assign mem_addr_o = addr_q;
  assign done_o     = (st_q == RD_WAIT) && mem_rvalid_i;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  assert_start_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == RD_IDLE) || done_o);
endmodule

// File: rtl/iommu_walker.sv
module iommu_walker
  import iommu_walk_pkg::*;
#(
  parameter int unsigned DEV_W   = 16,
  parameter int unsigned VA_W    = 64,
  parameter int unsigned PA_W    = 52,
  parameter int unsigned MAX_LVL = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     enable_i,
  input  logic [PA_W-PG_SHIFT-1:0] dtab_base_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [DEV_W-1:0]         req_dev_i,
  input  logic [VA_W-1:0]          req_addr_i,
  input  logic                     req_write_i,
  output logic                     rsp_valid_o,
  output logic                     rsp_fault_o,
  output logic [VA_W-1:0]          rsp_addr_o,
  output logic [VA_W-1:0]          rsp_len_o,
  output logic                     mem_req_o,
  output logic [PA_W-1:0]          mem_addr_o,
  input  logic                     mem_gnt_i,
  input  logic                     mem_rvalid_i,
  input  logic [ENT_W-1:0]         mem_rdata_i,
  output logic                     evt_valid_o,
  output logic [DEV_W-1:0]         evt_dev_o,
  output logic [DOM_W-1:0]         evt_domain_o,
  output logic [VA_W-1:0]          evt_addr_o,
  output logic                     evt_present_o,
  output logic                     evt_write_o
);
  localparam int unsigned ROOT_W  = PA_W - PG_SHIFT;
  localparam int unsigned MAX_RD  = MAX_LVL + 2;
  localparam int unsigned FCNT_W  = $clog2(MAX_RD + 2) + 1;

  walk_st_e         st_q;
  logic [DEV_W-1:0] dev_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [ROOT_W-1:0] root_q;
  logic [LVL_W-1:0] lvl_q;
  logic             pres_q, rd_q, wp_q;
  logic [DOM_W-1:0] dom_q;
  logic             fault_q, evp_q;
  logic [VA_W-1:0]  raddr_q, rlen_q;

  logic             rd_start, rd_done, sel_hi;
  logic [PA_W-1:0]  rd_addr, dte_addr, next_addr;
  logic [VA_W-1:0]  xlat_addr, xlat_len;
  logic [DEV_W-1:0] dev_sel;
  logic             cur_fault, new_bad;
  logic [LVL_W-1:0] new_lvl;
  logic             accept, dte_on;
  logic             unused_rdata;

  assign accept   = req_valid_i && (st_q == ST_IDLE);
  assign new_lvl  = mem_rdata_i[LVL_LSB +: LVL_W];
  assign dte_on   = mem_rdata_i[BIT_PRESENT] && mem_rdata_i[BIT_XLAT];
  assign dev_sel  = (st_q == ST_IDLE) ? req_dev_i : dev_q;
  assign sel_hi   = (st_q == ST_DTE0);
  assign unused_rdata = ^{mem_rdata_i[ENT_W-1], mem_rdata_i[BIT_RD-1:PA_W]};

  iw_addr_gen #(.DEV_W(DEV_W), .VA_W(VA_W), .PA_W(PA_W)) u_agen (
    .tbl_base_i (dtab_base_i),
    .dev_i      (dev_sel),
    .sel_hi_i   (sel_hi),
    .root_i     (root_q),
    .lvl_i      (lvl_q),
    .va_i       (va_q),
    .dte_addr_o (dte_addr),
    .next_addr_o(next_addr),
    .xlat_addr_o(xlat_addr),
    .xlat_len_o (xlat_len)
  );

  iw_entry_chk #(.MAX_LVL(MAX_LVL)) u_chk (
    .cur_present_i(pres_q),
    .cur_rd_i     (rd_q),
    .cur_wr_i     (wp_q),
    .cur_lvl_i    (lvl_q),
    .req_write_i  (wr_q),
    .new_lvl_i    (new_lvl),
    .cur_fault_o  (cur_fault),
    .new_bad_o    (new_bad)
  );

  iw_rd_port #(.PA_W(PA_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (rd_start),
    .addr_i      (rd_addr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i),
    .done_o      (rd_done)
  );

  always_comb begin
    rd_start = 1'b0;
    rd_addr  = dte_addr;
    unique case (st_q)
      ST_IDLE:  rd_start = accept && enable_i;
      ST_DTE0:  rd_start = rd_done && dte_on;
      ST_CHECK: begin
        rd_start = (lvl_q != '0) && !cur_fault;
        rd_addr  = next_addr;
      end
      default:  rd_start = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dev_q   <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      root_q  <= '0;
      lvl_q   <= '0;
      pres_q  <= 1'b0;
      rd_q    <= 1'b0;
      wp_q    <= 1'b0;
      dom_q   <= '0;
      fault_q <= 1'b0;
      evp_q   <= 1'b0;
      raddr_q <= '0;
      rlen_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          dev_q <= req_dev_i;
          va_q  <= req_addr_i;
          wr_q  <= req_write_i;
          dom_q <= '0;
          if (!enable_i) begin
            fault_q <= 1'b0;
            raddr_q <= req_addr_i;
            rlen_q  <= '1;
            st_q    <= ST_RESP;
          end else begin
            st_q <= ST_DTE0;
          end
        end
        ST_DTE0: if (rd_done) begin
          root_q <= mem_rdata_i[PG_SHIFT +: ROOT_W];
          lvl_q  <= new_lvl;
          pres_q <= mem_rdata_i[BIT_PRESENT];
          rd_q   <= mem_rdata_i[BIT_RD];
          wp_q   <= mem_rdata_i[BIT_WR];
          if (!dte_on) begin
            fault_q <= 1'b0;
            raddr_q <= va_q;
            rlen_q  <= '1;
            st_q    <= ST_RESP;
          end else begin
            st_q <= ST_DTE1;
          end
        end
        ST_DTE1: if (rd_done) begin
          dom_q <= mem_rdata_i[DOM_W-1:0];
          st_q  <= ST_CHECK;
        end
        ST_CHECK: begin
          if (lvl_q == '0) begin
            fault_q <= 1'b0;
            raddr_q <= xlat_addr;
            rlen_q  <= xlat_len;
            st_q    <= ST_RESP;
          end else if (cur_fault) begin
            fault_q <= 1'b1;
            evp_q   <= pres_q;
            st_q    <= ST_RESP;
          end else begin
            st_q <= ST_PTE;
          end
        end
        ST_PTE: if (rd_done) begin
          if (new_bad) begin
            fault_q <= 1'b1;
            evp_q   <= mem_rdata_i[BIT_PRESENT];
            st_q    <= ST_RESP;
          end else begin
            root_q <= mem_rdata_i[PG_SHIFT +: ROOT_W];
            lvl_q  <= new_lvl;
            pres_q <= mem_rdata_i[BIT_PRESENT];
            rd_q   <= mem_rdata_i[BIT_RD];
            wp_q   <= mem_rdata_i[BIT_WR];
            st_q   <= ST_CHECK;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign rsp_valid_o   = (st_q == ST_RESP);
  assign rsp_fault_o   = fault_q;
  assign rsp_addr_o    = raddr_q;
  assign rsp_len_o     = rlen_q;
  assign evt_valid_o   = rsp_valid_o && fault_q;
  assign evt_dev_o     = dev_q;
  assign evt_domain_o  = dom_q;
  assign evt_addr_o    = va_q;
  assign evt_present_o = evp_q;
  assign evt_write_o   = wr_q;

  // read count per translation, for the walk bound check
  logic [FCNT_W-1:0] fetch_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fetch_cnt_q <= '0;
    else if (accept)   fetch_cnt_q <= FCNT_W'(rd_start);
    else if (rd_start) fetch_cnt_q <= fetch_cnt_q + 1'b1;
  end

  assert_walk_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fetch_cnt_q) <= MAX_RD);

  assert_busy_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  assert_rsp_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  assert_leaf_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o && (rsp_len_o != '1)
      |-> (rsp_len_o + VA_W'(rsp_addr_o[PG_SHIFT-1:0])) == VA_W'(1 << PG_SHIFT));

  assert_off_no_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !enable_i |=> !mem_req_o && rsp_valid_o);
endmodule

// File: tb/sim_iommu_walker.sv
module sim_iommu_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b1;
  logic [39:0] dtab_base_i = 40'h100;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [15:0] req_dev_i = '0;
  logic [63:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        rsp_valid_o, rsp_fault_o;
  logic [63:0] rsp_addr_o, rsp_len_o;
  logic        mem_req_o;
  logic [51:0] mem_addr_o;
  logic        mem_gnt_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        evt_valid_o;
  logic [15:0] evt_dev_o, evt_domain_o;
  logic [63:0] evt_addr_o;
  logic        evt_present_o, evt_write_o;

  always #4 clk = ~clk;

  iommu_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable_i), .dtab_base_i(dtab_base_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_dev_i(req_dev_i),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i),
    .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o), .rsp_addr_o(rsp_addr_o),
    .rsp_len_o(rsp_len_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .evt_valid_o(evt_valid_o), .evt_dev_o(evt_dev_o), .evt_domain_o(evt_domain_o),
    .evt_addr_o(evt_addr_o), .evt_present_o(evt_present_o), .evt_write_o(evt_write_o)
  );

  typedef struct {
    logic        fault;
    logic [63:0] addr;
    logic [63:0] len;
    logic        evp;
    logic        evw;
    logic [15:0] dom;
    logic [15:0] dev;
    logic [63:0] va;
    int          fetches;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] mem [logic [63:0]];
  int          n_chk = 0;
  int          n_bad = 0;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] ent(input logic [39:0] root, input logic [2:0] lvl,
                                      input logic r, input logic w, input logic p,
                                      input logic tv);
    logic [63:0] e;
    e = '0;
    e[51:12] = root; e[11:9] = lvl; e[61] = r; e[62] = w; e[0] = p; e[1] = tv;
    return e;
  endfunction

  function automatic logic [63:0] idx_of(input logic [63:0] va, input int lvl);
    return (va >> (12 + 9 * (lvl - 1))) & 64'h1FF;
  endfunction

  function automatic logic [63:0] dte_at(input logic [15:0] dev);
    return {12'd0, dtab_base_i, 12'd0} + 64'(dev) * 64'd32;
  endfunction

  // expected walk derived from R1-style rules written per requirement
  function automatic exp_t ref_walk(input logic en, input logic [15:0] dev,
                                    input logic [63:0] va, input logic wr);
    exp_t e;
    logic [63:0] q0, q1, pte, nxt;
    int lvl, nl;
    bit done;
    e.fault = 0; e.addr = va; e.len = '1; e.evp = 0; e.evw = wr; e.dom = 0;
    e.dev = dev; e.va = va; e.fetches = 0; e.tag = "";
    if (!en) return e;
    q0 = rd(dte_at(dev)); e.fetches = 1;
    if (!q0[0] || !q0[1]) return e;
    q1 = rd(dte_at(dev) + 64'd8); e.fetches = 2; e.dom = q1[15:0];
    pte = q0; lvl = int'(pte[11:9]); done = 0;
    while (!done) begin
      if (lvl == 0) begin
        e.addr = {12'd0, pte[51:12], va[11:0]};
        e.len  = 64'd4096 - 64'(va[11:0]);
        done = 1;
      end else if (lvl == 7 || !pte[0] || !(wr ? pte[62] : pte[61])) begin
        e.fault = 1; e.evp = pte[0]; done = 1;
      end else begin
        nxt = rd({12'd0, pte[51:12], 12'd0} + idx_of(va, lvl) * 64'd8);
        e.fetches++;
        nl = int'(nxt[11:9]);
        if (nl == 7 || nl >= lvl) begin
          e.fault = 1; e.evp = nxt[0]; done = 1;
        end else begin
          pte = nxt; lvl = nl;
        end
      end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model + response monitor
  int fetch_cnt = 0;
  int gdelay = 0;
  int gseed = 0;
  bit pend = 0;
  int lat = 0;
  logic [63:0] paddr;
  bit rdy_next = 0;

  always @(negedge clk) begin
    mem_gnt_i    = 1'b0;
    mem_rvalid_i = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = rd(paddr);
        pend = 0;
      end else lat--;
    end else if (mem_req_o) begin
      if (gdelay == 0) begin
        mem_gnt_i = 1'b1;
        pend  = 1;
        paddr = 64'(mem_addr_o);
        lat   = gseed % 2;
        fetch_cnt++;
        gseed++;
        gdelay = gseed % 3;
      end else gdelay--;
    end

    if (rdy_next) begin
      check(req_ready_o === 1'b1, "R10 ready after response", 64'(req_ready_o), 64'd1);
      rdy_next = 0;
    end
    if (rsp_valid_o) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        check(0, "R10 unexpected response", 64'd1, 64'd0);
      end else begin
        e = sb_q.pop_front();
        check(rsp_fault_o === e.fault, {e.tag, " fault"}, 64'(rsp_fault_o), 64'(e.fault));
        check(evt_valid_o === e.fault, "R9 event strobe", 64'(evt_valid_o), 64'(e.fault));
        check(req_ready_o === 1'b0, "R10 ready low at response", 64'(req_ready_o), 64'd0);
        check(fetch_cnt == e.fetches, {e.tag, " R11 read count"}, 64'(fetch_cnt), 64'(e.fetches));
        if (!e.fault) begin
          check(rsp_addr_o === e.addr, {e.tag, " addr"}, rsp_addr_o, e.addr);
          check(rsp_len_o === e.len, {e.tag, " len"}, rsp_len_o, e.len);
        end else begin
          check(evt_present_o === e.evp, {e.tag, " R9 present"}, 64'(evt_present_o), 64'(e.evp));
          check(evt_write_o === e.evw, {e.tag, " R9 write"}, 64'(evt_write_o), 64'(e.evw));
          check(evt_domain_o === e.dom, {e.tag, " R9 domain"}, 64'(evt_domain_o), 64'(e.dom));
          check(evt_dev_o === e.dev, {e.tag, " R9 device"}, 64'(evt_dev_o), 64'(e.dev));
          check(evt_addr_o === e.va, {e.tag, " R9 addr"}, evt_addr_o, e.va);
        end
      end
      fetch_cnt = 0;
      rdy_next  = 1;
    end
  end

  task automatic send(input logic en, input logic [15:0] dev, input logic [63:0] va,
                      input logic wr, input string tag);
    exp_t e;
    e = ref_walk(en, dev, va, wr);
    e.tag = tag;
    while (!req_ready_o) @(negedge clk);
    enable_i = en; req_dev_i = dev; req_addr_i = va; req_write_i = wr;
    sb_q.push_back(e);
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(!req_ready_o, "R10 busy after accept", 64'(req_ready_o), 64'd0);
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic void set_dte(input logic [15:0] dev, input logic [63:0] q0,
                                  input logic [15:0] dom);
    mem[dte_at(dev)] = q0;
    mem[dte_at(dev) + 64'd8] = {48'd0, dom};
  endfunction

  initial begin
    logic [63:0] va1, va2, va6;
    va1 = 64'h0000_0040_2030_1ABC;
    va2 = 64'h0000_0000_1234_5678;
    va6 = 64'hFE12_3456_789A_BCDE;

    // three-level walk, RW
    set_dte(16'd5, ent(40'h200, 3'd3, 1, 1, 1, 1), 16'h1234);
    mem[64'h200000 + idx_of(va1, 3) * 8] = ent(40'h201, 3'd2, 1, 1, 1, 0);
    mem[64'h201000 + idx_of(va1, 2) * 8] = ent(40'h202, 3'd1, 1, 1, 1, 0);
    mem[64'h202000 + idx_of(va1, 1) * 8] = ent(40'h3ABCD, 3'd0, 1, 1, 1, 0);
    // read-only, one level
    set_dte(16'd6, ent(40'h210, 3'd1, 1, 0, 1, 1), 16'h0066);
    mem[64'h210000 + idx_of(va2, 1) * 8] = ent(40'h555, 3'd0, 1, 1, 1, 0);
    // not-present intermediate
    set_dte(16'd7, ent(40'h220, 3'd2, 1, 1, 1, 1), 16'h0077);
    mem[64'h220000 + idx_of(va2, 2) * 8] = ent(40'h221, 3'd1, 1, 1, 0, 0);
    // non-decreasing level
    set_dte(16'd8, ent(40'h230, 3'd2, 1, 1, 1, 1), 16'h0088);
    mem[64'h230000 + idx_of(va2, 2) * 8] = ent(40'h231, 3'd2, 1, 1, 1, 0);
    // device entry level 7
    set_dte(16'd9, ent(40'h240, 3'd7, 1, 1, 1, 1), 16'h0099);
    // level 0 directly in device entry
    set_dte(16'd10, ent(40'h777, 3'd0, 0, 0, 1, 1), 16'h00AA);
    // translation disabled / entry invalid
    set_dte(16'd11, ent(40'h888, 3'd1, 1, 1, 1, 0), 16'h00BB);
    set_dte(16'd12, ent(40'h888, 3'd1, 1, 1, 0, 1), 16'h00CC);
    // write-only
    set_dte(16'd13, ent(40'h250, 3'd1, 0, 1, 1, 1), 16'h00DD);
    mem[64'h250000 + idx_of(va2, 1) * 8] = ent(40'h666, 3'd0, 0, 0, 0, 0);
    // fetched level 7
    set_dte(16'd15, ent(40'h260, 3'd2, 1, 1, 1, 1), 16'h00FF);
    mem[64'h260000 + idx_of(va2, 2) * 8] = ent(40'h261, 3'd7, 1, 1, 1, 0);
    // six-level walk
    set_dte(16'd14, ent(40'h300, 3'd6, 1, 1, 1, 1), 16'h0E0E);
    for (int l = 6; l >= 1; l--) begin
      logic [63:0] tbl;
      tbl = 64'(40'h300 + 40'(6 - l)) << 12;
      mem[tbl + idx_of(va6, l) * 8] =
        ent((l == 1) ? 40'h9999 : 40'h300 + 40'(7 - l), 3'(l - 1), 1, 1, 1, 0);
    end
    // large device number, leaf in entry
    set_dte(16'h0103, ent(40'h1111, 3'd0, 0, 0, 1, 1), 16'h0103);

    repeat (3) @(negedge clk);
    // R12 reset state
    check(req_ready_o === 1'b1, "R12 ready", 64'(req_ready_o), 64'd1);
    check(rsp_valid_o === 1'b0, "R12 rsp_valid", 64'(rsp_valid_o), 64'd0);
    check(mem_req_o === 1'b0, "R12 mem_req", 64'(mem_req_o), 64'd0);
    check(evt_valid_o === 1'b0, "R12 evt_valid", 64'(evt_valid_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready_o === 1'b1 && !rsp_valid_o && !mem_req_o, "R12 after release",
          {61'd0, req_ready_o, rsp_valid_o, mem_req_o}, 64'd4);

    send(1'b0, 16'd5, va1, 1'b0, "R1 disabled passthrough");
    send(1'b1, 16'd5, va1, 1'b0, "R4 three-level read");
    send(1'b1, 16'd5, va1, 1'b1, "R4 three-level write");
    send(1'b1, 16'd5, va1 ^ 64'h3000, 1'b0, "R7 unmapped leaf of zeros");
    send(1'b1, 16'd6, va2, 1'b0, "R6 read-only read ok");
    send(1'b1, 16'd6, va2, 1'b1, "R6 read-only write fault");
    send(1'b1, 16'd13, va2, 1'b0, "R6 write-only read fault");
    send(1'b1, 16'd13, va2, 1'b1, "R7 write with unchecked leaf");
    send(1'b1, 16'd7, va2, 1'b0, "R5 not present");
    send(1'b1, 16'd8, va2, 1'b1, "R8 non-decreasing level");
    send(1'b1, 16'd15, va2, 1'b0, "R8 fetched level 7");
    send(1'b1, 16'd9, va2, 1'b0, "R8 entry level 7");
    send(1'b1, 16'd10, va2, 1'b0, "R7 level 0 entry");
    send(1'b1, 16'd10, 64'h0000_0000_0000_0000, 1'b0, "R7 offset zero len");
    send(1'b1, 16'd11, va2, 1'b0, "R3 translation off");
    send(1'b1, 16'd12, va2, 1'b1, "R3 entry invalid");
    send(1'b1, 16'd14, va6, 1'b0, "R4 six-level walk");
    send(1'b1, 16'h0103, 64'hABC_DFFF, 1'b1, "R2 large device");
    send(1'b0, 16'd14, va6, 1'b1, "R1 disabled write");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule